// File: doc/BRIEF.md
# Cluster Setup and Identity Register File

This block is the small register file that lives in a cluster's request demultiplexer. It keeps the values a compute core needs to know about itself and its surroundings: its own core number, the number of the cluster it belongs to, and the 4-bit global base that places the whole accelerator in the 32-bit address space. It also keeps one boot address per core and the level of the accelerator-wide reset. Cores only read it. Every read returns data in a fixed single clock cycle.

Only the host can write the registers. Before a task, the host places the accelerator in reset and then programs the base. It next loads each core's start address and then takes the accelerator out of reset. From that point on, the new base is what every core sees when it reads the base register. It is also what the base output presents to the DMA engines. A write to the base while the accelerator runs is dropped, and a sticky error flag records it. A core that tries to write any register gets an error response, and nothing changes.

Top module: `cluster_cfg_regs`

## Requirements
- R1: After rst_n is released, accel_rst_o is 1, glob_base_o is 0, cluster_id_o is 0, every boot address is 0, base_err_o is 0 and core_rvalid_o is 0.
- R2: A core read (core_req_i=1, core_we_i=0) at offset 0x30_0000 returns the requester's core_id_i, zero-extended to 32 bits.
- R3: A core read at offset 0x30_0004 returns the cluster ID in bits 4:0. A core read at offset 0x30_0008 returns the global base in bits 3:0. All other bits are zero.
- R4: A core read at any other offset returns zero with core_err_o=0. This includes offsets that are not word aligned.
- R5: core_rvalid_o is 1 in the cycle after each cycle in which core_req_i is 1, and 0 in the cycle after each cycle in which it is 0. Data and error travel with it.
- R6: A core write attempt (core_req_i=1, core_we_i=1) returns core_err_o=1 with zero data. No register or output changes because of it.
- R7: A host write to control offset 0x00 sets accel_rst_o to wdata bit 0. Writing 1 to bit 1 of the same write clears base_err_o.
- R8: A host write to base offset 0x04 loads wdata bits 3:0 into glob_base_o, but only while accel_rst_o is 1.
- R9: A host write to the base while accel_rst_o is 0 leaves the base unchanged and sets base_err_o. The flag stays set until it is cleared as described in R7.
- R10: A host write to offset 0x08 loads wdata bits 4:0 into cluster_id_o.
- R11: A host write to offset 0x40+4*i (i < NCORE) loads all 32 bits into the boot address of core i. This address appears on boot_addr_o bits [32*i+31:32*i]. Host writes to any other offset change nothing.
- R12: After a new base is programmed during reset and reset is released, core reads of the base return the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we_i | input | 1 | Host write strobe |
| host_addr_i | input | 8 | Host byte offset |
| host_wdata_i | input | 32 | Host write data |
| core_req_i | input | 1 | Core access request |
| core_we_i | input | 1 | Core access is a write attempt |
| core_ofs_i | input | 22 | Byte offset in the cluster alias window |
| core_id_i | input | 3 | Number of the requesting core |
| core_rvalid_o | output | 1 | Response valid, one cycle after the request |
| core_rdata_o | output | 32 | Read data |
| core_err_o | output | 1 | Error response for a write attempt |
| accel_rst_o | output | 1 | Accelerator reset level |
| glob_base_o | output | 4 | Global base, upper address nibble |
| cluster_id_o | output | 5 | Cluster number |
| boot_addr_o | output | 256 | Boot address of each core, packed |
| base_err_o | output | 1 | Sticky flag for a base write attempted while running |

## Verification
The assertions check on every cycle that the response follows each request by exactly one cycle. They also check that write attempts come back as errors with zero data, and that undefined offsets read as zero. Further properties check that the base cannot move while the accelerator runs, that a blocked base write raises the sticky flag, and that a core write alters no output. Only the bench scenarios can show the actual values returned per core number and the boot address placement for each slot. The same holds for the complete host sequence of reset, program and release, and for the reads that follow it with the new base.

// File: rtl/ccfg_pkg.sv
package ccfg_pkg;

  localparam int OFS_W  = 22;
  localparam int HADDR_W = 8;
  localparam int DATA_W = 32;

  localparam logic [OFS_W-1:0]   OFS_CORE_ID = 22'h30_0000;
  localparam logic [OFS_W-1:0]   OFS_CLID    = 22'h30_0004;
  localparam logic [OFS_W-1:0]   OFS_BASE    = 22'h30_0008;

  localparam logic [HADDR_W-1:0] HOFS_CTRL   = 8'h00;
  localparam logic [HADDR_W-1:0] HOFS_BASE   = 8'h04;
  localparam logic [HADDR_W-1:0] HOFS_CLID   = 8'h08;
  localparam logic [HADDR_W-1:0] HOFS_BOOT0  = 8'h40;

  typedef enum logic [1:0] {
    CSEL_NONE,
    CSEL_CORE_ID,
    CSEL_CLID,
    CSEL_BASE
  } csel_e;

  typedef enum logic [2:0] {
    HSEL_NONE,
    HSEL_CTRL,
    HSEL_BASE,
    HSEL_CLID,
    HSEL_BOOT
  } hsel_e;

  // Core-side offset decode
  function automatic csel_e core_decode(input logic [OFS_W-1:0] ofs);
    csel_e s;
    case (ofs)
      OFS_CORE_ID: s = CSEL_CORE_ID;
      OFS_CLID:    s = CSEL_CLID;
      OFS_BASE:    s = CSEL_BASE;
      default:     s = CSEL_NONE;
    endcase
    return s;
  endfunction

  // Boot slot number from a host offset
  function automatic int boot_slot(input logic [HADDR_W-1:0] a);
    return (int'(a) - int'(HOFS_BOOT0)) >>> 2;
  endfunction

  // Host-side offset decode
  function automatic hsel_e host_decode(input logic [HADDR_W-1:0] a,
                                        input int ncore);
    hsel_e s;
    s = HSEL_NONE;
    if (a[1:0] == 2'b00) begin
      if (a == HOFS_CTRL)       s = HSEL_CTRL;
      else if (a == HOFS_BASE)  s = HSEL_BASE;
      else if (a == HOFS_CLID)  s = HSEL_CLID;
      else if (a >= HOFS_BOOT0 && boot_slot(a) < ncore) s = HSEL_BOOT;
    end
    return s;
  endfunction

endpackage

// File: rtl/ccfg_host_regs.sv
module ccfg_host_regs
  import ccfg_pkg::*;
#(
  parameter int NCORE  = 8,
  parameter int BASE_W = 4,
  parameter int CLID_W = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    host_we_i,
  input  logic [HADDR_W-1:0]      host_addr_i,
  input  logic [DATA_W-1:0]       host_wdata_i,
  output logic                    accel_rst_o,
  output logic [BASE_W-1:0]       base_o,
  output logic [CLID_W-1:0]       clid_o,
  output logic [NCORE*DATA_W-1:0] boot_o,
  output logic                    base_err_o
);

  hsel_e hsel;
  logic  accel_rst_q;
  logic [BASE_W-1:0] base_q;
  logic [CLID_W-1:0] clid_q;
  logic  err_q;

  // Named events for the checks below
  logic base_wr_ok;
  logic base_wr_blocked;
  logic err_clr;
  logic ctrl_wr;

  assign hsel            = host_decode(host_addr_i, NCORE);
  assign ctrl_wr         = host_we_i && (hsel == HSEL_CTRL);
  assign base_wr_ok      = host_we_i && (hsel == HSEL_BASE) && accel_rst_q;
  assign base_wr_blocked = host_we_i && (hsel == HSEL_BASE) && !accel_rst_q;
  assign err_clr         = ctrl_wr && host_wdata_i[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      accel_rst_q <= 1'b1;
      base_q      <= '0;
      clid_q      <= '0;
      err_q       <= 1'b0;
    end else begin
      if (ctrl_wr) accel_rst_q <= host_wdata_i[0];
      if (base_wr_ok) base_q <= host_wdata_i[BASE_W-1:0];
      if (host_we_i && (hsel == HSEL_CLID)) clid_q <= host_wdata_i[CLID_W-1:0];
      if (base_wr_blocked)  err_q <= 1'b1;
      else if (err_clr)     err_q <= 1'b0;
    end
  end

  for (genvar i = 0; i < NCORE; i++) begin : g_boot
    logic [DATA_W-1:0] boot_q;
    logic              slot_hit;
    assign slot_hit = host_we_i && (hsel == HSEL_BOOT) && (boot_slot(host_addr_i) == i);
    always_ff @(posedge clk) begin
      if (!rst_n)        boot_q <= '0;
      else if (slot_hit) boot_q <= host_wdata_i;
    end
    assign boot_o[i*DATA_W +: DATA_W] = boot_q;
  end

  assign accel_rst_o = accel_rst_q;
  assign base_o      = base_q;
  assign clid_o      = clid_q;
  assign base_err_o  = err_q;

  // R8: base frozen while the accelerator runs
  p_base_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !accel_rst_q |=> $stable(base_q));

  // R9: a blocked base write raises the flag
  p_blocked_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    base_wr_blocked |=> err_q);

  // R9: the flag holds until cleared
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_q && !err_clr |=> err_q);

  // R7: a control write sets the reset level
  p_ctrl_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (accel_rst_q == $past(host_wdata_i[0])));

endmodule

// File: rtl/ccfg_core_port.sv
module ccfg_core_port
  import ccfg_pkg::*;
#(
  parameter int CORE_W = 3,
  parameter int BASE_W = 4,
  parameter int CLID_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic [CORE_W-1:0] core_id_i,
  input  logic [CLID_W-1:0] clid_i,
  input  logic [BASE_W-1:0] base_i,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o
);

  csel_e             csel;
  logic [DATA_W-1:0] rd_mux;
  logic              rd_ev;
  logic              wr_ev;
  logic              rvalid_q;
  logic              err_q;
  logic [DATA_W-1:0] rdata_q;

  assign csel  = core_decode(ofs_i);
  assign rd_ev = req_i && !we_i;
  assign wr_ev = req_i && we_i;

  always_comb begin
    rd_mux = '0;
    case (csel)
      CSEL_CORE_ID: rd_mux[CORE_W-1:0] = core_id_i;
      CSEL_CLID:    rd_mux[CLID_W-1:0] = clid_i;
      CSEL_BASE:    rd_mux[BASE_W-1:0] = base_i;
      default:      rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      err_q    <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= req_i;
      err_q    <= wr_ev;
      rdata_q  <= rd_ev ? rd_mux : '0;
    end
  end

  assign rvalid_o = rvalid_q;
  assign err_o    = err_q;
  assign rdata_o  = rdata_q;

  // R5: response one cycle after each request
  p_resp_next_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> rvalid_o);

  // R5: no response without a request
  p_no_spurious_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> !rvalid_o);

  // R6: write attempts return an error with zero data
  p_write_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ev |=> (err_o && rdata_o == '0));

  // R4: undefined offsets read as zero without error
  p_undef_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ev && (csel == CSEL_NONE) |=> (rdata_o == '0 && !err_o));

  // R2: reads never flag an error
  p_read_ok_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ev |=> !err_o);

endmodule

// File: rtl/cluster_cfg_regs.sv
module cluster_cfg_regs
  import ccfg_pkg::*;
#(
  parameter int NCORE  = 8,
  parameter int BASE_W = 4,
  parameter int CLID_W = 5,
  localparam int CORE_W = (NCORE > 1) ? $clog2(NCORE) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    host_we_i,
  input  logic [HADDR_W-1:0]      host_addr_i,
  input  logic [DATA_W-1:0]       host_wdata_i,
  input  logic                    core_req_i,
  input  logic                    core_we_i,
  input  logic [OFS_W-1:0]        core_ofs_i,
  input  logic [CORE_W-1:0]       core_id_i,
  output logic                    core_rvalid_o,
  output logic [DATA_W-1:0]       core_rdata_o,
  output logic                    core_err_o,
  output logic                    accel_rst_o,
  output logic [BASE_W-1:0]       glob_base_o,
  output logic [CLID_W-1:0]       cluster_id_o,
  output logic [NCORE*DATA_W-1:0] boot_addr_o,
  output logic                    base_err_o
);

  logic [BASE_W-1:0] base_w;
  logic [CLID_W-1:0] clid_w;
  logic              core_wr_attempt;

  assign core_wr_attempt = core_req_i && core_we_i;

  ccfg_host_regs #(
    .NCORE  (NCORE),
    .BASE_W (BASE_W),
    .CLID_W (CLID_W)
  ) u_host (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_we_i    (host_we_i),
    .host_addr_i  (host_addr_i),
    .host_wdata_i (host_wdata_i),
    .accel_rst_o  (accel_rst_o),
    .base_o       (base_w),
    .clid_o       (clid_w),
    .boot_o       (boot_addr_o),
    .base_err_o   (base_err_o)
  );

  ccfg_core_port #(
    .CORE_W (CORE_W),
    .BASE_W (BASE_W),
    .CLID_W (CLID_W)
  ) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (core_req_i),
    .we_i      (core_we_i),
    .ofs_i     (core_ofs_i),
    .core_id_i (core_id_i),
    .clid_i    (clid_w),
    .base_i    (base_w),
    .rvalid_o  (core_rvalid_o),
    .rdata_o   (core_rdata_o),
    .err_o     (core_err_o)
  );

  assign glob_base_o  = base_w;
  assign cluster_id_o = clid_w;

  // R6: a core write attempt with no host write alters no output
  p_core_wr_inert_r6: assert property (@(posedge clk) disable iff (!rst_n)
    core_wr_attempt && !host_we_i |=>
      ($stable(glob_base_o) && $stable(cluster_id_o) &&
       $stable(boot_addr_o) && $stable(accel_rst_o) && $stable(base_err_o)));

  // R12: base reads return the current base register
  p_base_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
    core_req_i && !core_we_i && (core_ofs_i == OFS_BASE) && !host_we_i |=>
      (core_rdata_o == {{(DATA_W-BASE_W){1'b0}}, glob_base_o}));

endmodule

// File: tb/test_cluster_cfg_regs.sv
module test_cluster_cfg_regs;

  localparam int NC = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          host_we = 1'b0;
  logic [7:0]    host_addr = '0;
  logic [31:0]   host_wdata = '0;
  logic          core_req = 1'b0;
  logic          core_we = 1'b0;
  logic [21:0]   core_ofs = '0;
  logic [2:0]    core_id = '0;
  logic          core_rvalid;
  logic [31:0]   core_rdata;
  logic          core_err;
  logic          accel_rst;
  logic [3:0]    glob_base;
  logic [4:0]    cluster_id;
  logic [NC*32-1:0] boot_addr;
  logic          base_err;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cluster_cfg_regs i_cluster_cfg_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .host_we_i     (host_we),
    .host_addr_i   (host_addr),
    .host_wdata_i  (host_wdata),
    .core_req_i    (core_req),
    .core_we_i     (core_we),
    .core_ofs_i    (core_ofs),
    .core_id_i     (core_id),
    .core_rvalid_o (core_rvalid),
    .core_rdata_o  (core_rdata),
    .core_err_o    (core_err),
    .accel_rst_o   (accel_rst),
    .glob_base_o   (glob_base),
    .cluster_id_o  (cluster_id),
    .boot_addr_o   (boot_addr),
    .base_err_o    (base_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  // One core access; result checked one cycle later
  task automatic core_access(input logic we, input logic [21:0] ofs, input logic [2:0] id,
                             input string req, input logic [31:0] exp_data, input logic exp_err);
    @(negedge clk);
    core_req = 1'b1; core_we = we; core_ofs = ofs; core_id = id;
    @(negedge clk);
    core_req = 1'b0; core_we = 1'b0;
    check({req, " rvalid"}, {31'd0, core_rvalid}, 32'd1);
    check({req, " data"}, core_rdata, exp_data);
    check({req, " err"}, {31'd0, core_err}, {31'd0, exp_err});
  endtask

  task automatic t_reset;
    check("R1 accel_rst", {31'd0, accel_rst}, 32'd1);
    check("R1 base", {28'd0, glob_base}, 32'd0);
    check("R1 cluster", {27'd0, cluster_id}, 32'd0);
    check("R1 err", {31'd0, base_err}, 32'd0);
    check("R1 rvalid", {31'd0, core_rvalid}, 32'd0);
    for (int i = 0; i < NC; i++) check("R1 boot", boot_addr[i*32 +: 32], 32'd0);
  endtask

  task automatic t_setup;
    host_write(8'h04, 32'hFFFF_FFF1);
    check("R8 base in reset", {28'd0, glob_base}, 32'h1);
    host_write(8'h08, 32'h0000_00E5);
    check("R10 cluster id", {27'd0, cluster_id}, 32'h5);
    for (int i = 0; i < NC; i++) host_write(8'h40 + 8'(4*i), 32'h1C00_0000 + 32'(i * 32'h100));
    for (int i = 0; i < NC; i++)
      check("R11 boot slot", boot_addr[i*32 +: 32], 32'h1C00_0000 + 32'(i * 32'h100));
    host_write(8'h0C, 32'hDEAD_BEEF);
    host_write(8'h42, 32'hDEAD_BEEF);
    host_write(8'h60, 32'hDEAD_BEEF);
    check("R11 stray write base", {28'd0, glob_base}, 32'h1);
    check("R11 stray write cluster", {27'd0, cluster_id}, 32'h5);
    check("R11 stray write slot0", boot_addr[31:0], 32'h1C00_0000);
    check("R11 stray write slot7", boot_addr[7*32 +: 32], 32'h1C00_0700);
  endtask

  task automatic t_release;
    host_write(8'h00, 32'h0);
    check("R7 release", {31'd0, accel_rst}, 32'd0);
  endtask

  task automatic t_core_reads;
    for (int i = 0; i < NC; i++) core_access(1'b0, 22'h30_0000, 3'(i), "R2 core id", 32'(i), 1'b0);
    core_access(1'b0, 22'h30_0004, 3'd6, "R3 cluster id", 32'h5, 1'b0);
    core_access(1'b0, 22'h30_0008, 3'd2, "R3 base", 32'h1, 1'b0);
  endtask

  task automatic t_undef;
    core_access(1'b0, 22'h30_000C, 3'd1, "R4 past block", 32'h0, 1'b0);
    core_access(1'b0, 22'h00_0000, 3'd1, "R4 low offset", 32'h0, 1'b0);
    core_access(1'b0, 22'h30_0001, 3'd1, "R4 unaligned", 32'h0, 1'b0);
  endtask

  task automatic t_core_write;
    core_ofs = 22'h30_0008;
    core_access(1'b1, 22'h30_0008, 3'd3, "R6 write base", 32'h0, 1'b1);
    core_access(1'b1, 22'h30_0004, 3'd3, "R6 write cluster", 32'h0, 1'b1);
    check("R6 base kept", {28'd0, glob_base}, 32'h1);
    check("R6 cluster kept", {27'd0, cluster_id}, 32'h5);
    check("R6 no err flag", {31'd0, base_err}, 32'd0);
    core_access(1'b0, 22'h30_0008, 3'd3, "R6 base reads old", 32'h1, 1'b0);
  endtask

  task automatic t_rvalid_timing;
    @(negedge clk);
    core_req = 1'b1; core_we = 1'b0; core_ofs = 22'h30_0000; core_id = 3'd4;
    @(negedge clk);
    check("R5 first beat", {31'd0, core_rvalid}, 32'd1);
    core_id = 3'd7;
    @(negedge clk);
    core_req = 1'b0;
    check("R5 second beat", {31'd0, core_rvalid}, 32'd1);
    check("R5 second data", core_rdata, 32'd7);
    @(negedge clk);
    check("R5 idle", {31'd0, core_rvalid}, 32'd0);
  endtask

  task automatic t_base_running;
    host_write(8'h04, 32'h7);
    check("R9 base unchanged", {28'd0, glob_base}, 32'h1);
    check("R9 flag set", {31'd0, base_err}, 32'd1);
    host_write(8'h00, 32'h0);
    check("R9 flag sticky", {31'd0, base_err}, 32'd1);
    host_write(8'h00, 32'h3);
    check("R7 clear flag", {31'd0, base_err}, 32'd0);
    check("R7 reset asserted", {31'd0, accel_rst}, 32'd1);
  endtask

  task automatic t_rebase;
    host_write(8'h04, 32'h3);
    check("R8 rebase", {28'd0, glob_base}, 32'h3);
    check("R8 no flag", {31'd0, base_err}, 32'd0);
    host_write(8'h00, 32'h0);
    core_access(1'b0, 22'h30_0008, 3'd0, "R12 new base", 32'h3, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_setup;
    t_release;
    t_core_reads;
    t_undef;
    t_core_write;
    t_rvalid_timing;
    t_base_running;
    t_rebase;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule